// File: doc/BRIEF.md
# Multibit Trie Longest-Prefix-Match Engine

This block finds the longest matching route prefix for a 32-bit destination address. The routes are held as a multibit trie in an internal node store. Each node covers one stride of address bits and carries two bitmaps and two base pointers. One bitmap, the prefix map, marks the route prefixes held inside the node. The other, the branch map, marks which child subtries exist. The children of a node sit in consecutive node slots, and the next-hop values sit in a separate result store. Because of this layout, a child slot and a result slot are both found by counting set bits below a position and adding the count to a base pointer.

Each lookup is accepted through a valid/ready handshake. The engine then reads one node per clock from the root down. While it walks, it keeps only the result-store index of the deepest prefix matched so far. After the walk it reads the result store once and presents the next-hop through a second valid/ready handshake. Software fills both stores through two plain write ports while the engine is idle.

Top module: `tbm_lookup`

## Requirements
- R1: `req_ready` is high exactly when no lookup is in progress. It drops on the clock edge that accepts a request and stays low until the response has been taken with `rsp_ready`. `req_ready` and `rsp_valid` are never high together.
- R2: A node word holds four fields, from the least significant bit upward: the result base (RES_AW bits), the child base (NODE_AW bits), the branch map (2^STRIDE bits) and the prefix map (2^STRIDE-1 bits). The root is at node slot 0. A write to either store takes effect for every lookup accepted after it.
- R3: The address is consumed from the MSB downward, STRIDE bits per node, and this stride value is called the chunk. The walk moves to a child only when the branch-map bit indexed by the chunk is set. The child slot is the child base plus the number of set branch-map bits below that index.
- R4: A prefix of length L (0 ≤ L < STRIDE) whose value is the top L bits of the chunk sits at prefix-map bit (2^L − 1) + value. The longest set candidate in a node wins. A match in a deeper node replaces any shallower one, and a node with no match keeps the earlier one.
- R5: The result index is the node's result base plus the number of set prefix-map bits below the winning bit. The result store is read once per lookup, after the walk.
- R6: When no node on the path matched, the response carries the next-hop DEFAULT_NH with `rsp_miss` high. Otherwise `rsp_miss` is low.
- R7: When a lookup visits d nodes, `rsp_valid` rises on the d-th clock edge after the edge that accepted the request.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_nh` and `rsp_miss` hold their values.
- R9: A walk visits at most ADDR_W/STRIDE nodes. The branch map of the node at the last level is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_we | input | 1 | Node store write strobe |
| node_waddr | input | NODE_AW | Node slot to write |
| node_wdata | input | 2^(STRIDE+1)-1+NODE_AW+RES_AW | Node word (layout in R2) |
| res_we | input | 1 | Result store write strobe |
| res_waddr | input | RES_AW | Result slot to write |
| res_wdata | input | NH_W | Next-hop value to write |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Address to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_nh | output | NH_W | Next-hop of the longest match |
| rsp_miss | output | 1 | No prefix matched |

## Verification
The bench uses ADDR_W 32 and STRIDE 4, which gives eight levels and 15-bit prefix maps. NODE_AW and RES_AW are both 6, NH_W is 8, and DEFAULT_NH is set to 8'hEE so that a miss cannot be taken for a stored next-hop. With these values a self-looping node can drive a walk to the full eight-node depth limit. A small trie can also place branch and prefix bits so that the bit counts below a position are nonzero, and it can cover every prefix length inside one node.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WALK = 2'd1,
      ST_DONE = 2'd2
   } walk_state_e;

   // first prefix-map bit used by prefixes of a given length
   function automatic int unsigned len_base(input int unsigned len);
      return (32'd1 << len) - 32'd1;
   endfunction

endpackage

// File: rtl/tbm_store.sv
module tbm_store #(
   parameter int W  = 8,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   if (W < 1) begin : g_bad_w
      $error("tbm_store: W must be positive");
   end
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("tbm_store: AW out of range");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/tbm_node_eval.sv
module tbm_node_eval import tbm_pkg::*; #(
   parameter int S       = 4,
   parameter int NODE_AW = 6,
   parameter int RES_AW  = 6
) (
   input  logic [(1<<S)-2:0]  pfx_map,
   input  logic [(1<<S)-1:0]  br_map,
   input  logic [S-1:0]       chunk,
   input  logic [RES_AW-1:0]  res_base,
   input  logic [NODE_AW-1:0] child_base,
   output logic               hit,
   output logic [RES_AW-1:0]  res_idx,
   output logic               descend,
   output logic [NODE_AW-1:0] child_idx
);
   localparam int IW = (1 << S) - 1;
   localparam int EW = 1 << S;

   logic [S-1:0] cand_pos [S];
   logic [S-1:0] cand_hit;
   logic [S-1:0] win_pos;
   logic [IW:0]  pfx_below;
   logic [EW:0]  br_below;

   // one candidate per prefix length
   for (genvar l = 0; l < S; l++) begin : g_len
      if (l == 0) begin : g_root
         assign cand_pos[l] = '0;
      end else begin : g_deep
         assign cand_pos[l] = S'(len_base(l)) + {{(S-l){1'b0}}, chunk[S-1 -: l]};
      end
      assign cand_hit[l] = pfx_map[cand_pos[l]];
   end

   // later (longer) lengths override shorter ones
   always_comb begin
      hit     = 1'b0;
      win_pos = '0;
      for (int l = 0; l < S; l++) begin
         if (cand_hit[l]) begin
            hit     = 1'b1;
            win_pos = cand_pos[l];
         end
      end
   end

   assign pfx_below = ((IW+1)'(1) << win_pos) - (IW+1)'(1);
   assign br_below  = ((EW+1)'(1) << chunk) - (EW+1)'(1);

   assign res_idx   = res_base + RES_AW'($countones(pfx_map & pfx_below[IW-1:0]));
   assign descend   = br_map[chunk];
   assign child_idx = child_base + NODE_AW'($countones(br_map & br_below[EW-1:0]));

endmodule

// File: rtl/tbm_lookup.sv
module tbm_lookup import tbm_pkg::*; #(
   parameter int              ADDR_W     = 32,
   parameter int              STRIDE     = 4,
   parameter int              NODE_AW    = 6,
   parameter int              RES_AW     = 6,
   parameter int              NH_W       = 8,
   parameter logic [NH_W-1:0] DEFAULT_NH = '0
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         node_we,
   input  logic [NODE_AW-1:0]                           node_waddr,
   input  logic [(2<<STRIDE)+NODE_AW+RES_AW-2:0]        node_wdata,
   input  logic                                         res_we,
   input  logic [RES_AW-1:0]                            res_waddr,
   input  logic [NH_W-1:0]                              res_wdata,
   input  logic                                         req_valid,
   output logic                                         req_ready,
   input  logic [ADDR_W-1:0]                            req_addr,
   output logic                                         rsp_valid,
   input  logic                                         rsp_ready,
   output logic [NH_W-1:0]                              rsp_nh,
   output logic                                         rsp_miss
);
   localparam int IW     = (1 << STRIDE) - 1;
   localparam int EW     = 1 << STRIDE;
   localparam int NODE_W = IW + EW + NODE_AW + RES_AW;
   localparam int LEVELS = ADDR_W / STRIDE;
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int F_CB   = RES_AW;
   localparam int F_BR   = RES_AW + NODE_AW;
   localparam int F_PFX  = RES_AW + NODE_AW + EW;

   if (STRIDE < 1 || STRIDE > 8) begin : g_bad_stride
      $error("tbm_lookup: STRIDE must be 1..8");
   end
   if (ADDR_W % STRIDE != 0) begin : g_bad_split
      $error("tbm_lookup: ADDR_W must be a multiple of STRIDE");
   end
   if (NH_W < 1) begin : g_bad_nh
      $error("tbm_lookup: NH_W must be positive");
   end

   walk_state_e         state;
   logic [LVL_W-1:0]    level;
   logic [ADDR_W-1:0]   addr_q;
   logic                best_hit;
   logic [RES_AW-1:0]   best_idx;
   logic                miss_q;

   logic [NODE_W-1:0]   node_q;
   logic [NH_W-1:0]     res_q;

   logic                ev_hit;
   logic [RES_AW-1:0]   ev_res_idx;
   logic                ev_descend;
   logic [NODE_AW-1:0]  ev_child;

   logic                accept;
   logic                last_lvl;
   logic                go_deeper;
   logic                walk_end;
   logic                node_re;
   logic [NODE_AW-1:0]  node_raddr;
   logic                res_re;
   logic [RES_AW-1:0]   res_raddr;

   tbm_store #(.W(NODE_W), .AW(NODE_AW)) u_nodes (
      .clk   (clk),
      .we    (node_we),
      .waddr (node_waddr),
      .wdata (node_wdata),
      .re    (node_re),
      .raddr (node_raddr),
      .rdata (node_q)
   );

   tbm_store #(.W(NH_W), .AW(RES_AW)) u_results (
      .clk   (clk),
      .we    (res_we),
      .waddr (res_waddr),
      .wdata (res_wdata),
      .re    (res_re),
      .raddr (res_raddr),
      .rdata (res_q)
   );

   tbm_node_eval #(.S(STRIDE), .NODE_AW(NODE_AW), .RES_AW(RES_AW)) u_eval (
      .pfx_map    (node_q[F_PFX +: IW]),
      .br_map     (node_q[F_BR +: EW]),
      .chunk      (addr_q[ADDR_W-1 -: STRIDE]),
      .res_base   (node_q[RES_AW-1:0]),
      .child_base (node_q[F_CB +: NODE_AW]),
      .hit        (ev_hit),
      .res_idx    (ev_res_idx),
      .descend    (ev_descend),
      .child_idx  (ev_child)
   );

   assign accept     = (state == ST_IDLE) && req_valid;
   assign last_lvl   = (level == LVL_W'(LEVELS - 1));
   assign go_deeper  = (state == ST_WALK) && ev_descend && !last_lvl;
   assign walk_end   = (state == ST_WALK) && !go_deeper;

   assign node_re    = accept || go_deeper;
   assign node_raddr = (state == ST_WALK) ? ev_child : '0;
   assign res_re     = walk_end;
   assign res_raddr  = ev_hit ? ev_res_idx : best_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         level    <= '0;
         addr_q   <= '0;
         best_hit <= 1'b0;
         best_idx <= '0;
         miss_q   <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state    <= ST_WALK;
                  level    <= '0;
                  addr_q   <= req_addr;
                  best_hit <= 1'b0;
               end
            end
            ST_WALK: begin
               if (ev_hit) begin
                  best_hit <= 1'b1;
                  best_idx <= ev_res_idx;
               end
               if (go_deeper) begin
                  level  <= level + LVL_W'(1);
                  addr_q <= addr_q << STRIDE;
               end else begin
                  state  <= ST_DONE;
                  miss_q <= !(best_hit || ev_hit);
               end
            end
            ST_DONE: begin
               if (rsp_ready) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = (state == ST_DONE);
   assign rsp_miss  = miss_q;
   assign rsp_nh    = miss_q ? DEFAULT_NH : res_q;

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R1
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && rsp_valid)); // R1
   AST_SINGLE_RESULT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !res_re); // R5
   AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_nh == DEFAULT_NH)); // R6
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_nh) && $stable(rsp_miss))); // R8
   AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WALK && last_lvl) |=> (state == ST_DONE)); // R9

endmodule

// File: tb/tbm_lookup_test.sv
module tbm_lookup_test;
   localparam int          AW  = 32;
   localparam int          S   = 4;
   localparam int          NA  = 6;
   localparam int          RA  = 6;
   localparam int          NW  = 8;
   localparam logic [7:0]  DEF = 8'hEE;
   localparam int          NWD = 15 + 16 + NA + RA;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic node_we = 1'b0;
   logic [NA-1:0] node_waddr = '0;
   logic [NWD-1:0] node_wdata = '0;
   logic res_we = 1'b0;
   logic [RA-1:0] res_waddr = '0;
   logic [NW-1:0] res_wdata = '0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic rsp_valid;
   logic rsp_ready = 1'b1;
   logic [NW-1:0] rsp_nh;
   logic rsp_miss;

   always #10 clk = ~clk;

   tbm_lookup #(.ADDR_W(AW), .STRIDE(S), .NODE_AW(NA), .RES_AW(RA),
                .NH_W(NW), .DEFAULT_NH(DEF)) uut (
      .clk(clk), .rst_n(rst_n),
      .node_we(node_we), .node_waddr(node_waddr), .node_wdata(node_wdata),
      .res_we(res_we), .res_waddr(res_waddr), .res_wdata(res_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_nh(rsp_nh), .rsp_miss(rsp_miss)
   );

   int vectors = 0;
   int fails = 0;

   // shadow copies of what software wrote
   logic [14:0] sh_pfx [64];
   logic [15:0] sh_br  [64];
   int          sh_cb  [64];
   int          sh_rb  [64];
   logic [7:0]  sh_res [64];

   // behavioural reference
   bit         m_busy = 1'b0;
   int         m_cnt = 0;
   int         m_depth = 0;
   logic [7:0] m_nh = '0;
   bit         m_miss = 1'b0;
   string      cur_tag = "R1";

   function automatic void ref_lookup(input logic [31:0] a, output logic [7:0] nh,
                                      output bit miss, output int depth);
      int node;
      bit found;
      int ridx;
      node = 0; found = 0; ridx = 0; depth = 0;
      for (int lv = 0; lv < 8; lv++) begin
         int c;
         int k;
         c = int'((a >> (28 - 4*lv)) & 32'hF);
         depth++;
         for (int l = 3; l >= 0; l--) begin
            int p;
            p = (1 << l) - 1 + (c >> (4 - l));
            if (sh_pfx[node][p]) begin
               k = 0;
               for (int j = 0; j < p; j++) k += int'(sh_pfx[node][j]);
               ridx = (sh_rb[node] + k) % 64;
               found = 1;
               break;
            end
         end
         if (!sh_br[node][c] || lv == 7) break;
         k = 0;
         for (int j = 0; j < c; j++) k += int'(sh_br[node][j]);
         node = (sh_cb[node] + k) % 64;
      end
      miss = !found;
      nh = found ? sh_res[ridx] : DEF;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 1'b0;
      end else if (!m_busy) begin
         if (req_valid) begin
            logic [7:0] n;
            bit mi;
            int d;
            ref_lookup(req_addr, n, mi, d);
            m_busy  <= 1'b1;
            m_cnt   <= 0;
            m_depth <= d;
            m_nh    <= n;
            m_miss  <= mi;
         end
      end else if (m_cnt >= m_depth && rsp_ready) begin
         m_busy <= 1'b0;
      end else begin
         m_cnt <= m_cnt + 1;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit ev;
         ev = m_busy && (m_cnt >= m_depth);
         vectors++;
         if (req_ready !== !m_busy) begin
            fails++;
            $display("FAIL R1 req_ready actual %0b expected %0b", req_ready, !m_busy);
         end
         vectors++;
         if (rsp_valid !== ev) begin
            fails++;
            $display("FAIL R7 rsp_valid actual %0b expected %0b (depth %0d)", rsp_valid, ev, m_depth);
         end
         if (ev && rsp_valid) begin
            vectors++;
            if (rsp_nh !== m_nh || rsp_miss !== m_miss) begin
               fails++;
               $display("FAIL %s nh/miss actual %h/%0b expected %h/%0b",
                        cur_tag, rsp_nh, rsp_miss, m_nh, m_miss);
            end
         end
      end
   end

   task automatic wr_node(input int idx, input logic [14:0] pf, input logic [15:0] br,
                          input int cb, input int rb);
      @(negedge clk);
      node_we = 1'b1;
      node_waddr = NA'(idx);
      node_wdata = {pf, br, NA'(cb), RA'(rb)};
      sh_pfx[idx] = pf; sh_br[idx] = br; sh_cb[idx] = cb; sh_rb[idx] = rb;
      @(negedge clk);
      node_we = 1'b0;
   endtask

   task automatic wr_res(input int idx, input logic [7:0] v);
      @(negedge clk);
      res_we = 1'b1;
      res_waddr = RA'(idx);
      res_wdata = v;
      sh_res[idx] = v;
      @(negedge clk);
      res_we = 1'b0;
   endtask

   task automatic do_lookup(input logic [31:0] a, input string tag, input int hold);
      @(negedge clk);
      cur_tag = tag;
      rsp_ready = (hold == 0);
      req_addr = a;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (hold) @(negedge clk);
      rsp_ready = 1'b1;
      while (m_busy) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         sh_pfx[i] = '0; sh_br[i] = '0; sh_cb[i] = 0; sh_rb[i] = 0; sh_res[i] = '0;
      end
      repeat (3) @(negedge clk);
      vectors++;
      if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset ready/valid actual %0b/%0b expected 1/0", req_ready, rsp_valid);
      end
      rst_n = 1'b1;

      // empty root: every address misses (R6)
      wr_node(0, 15'h0000, 16'h0000, 0, 0);
      do_lookup(32'h1234_5678, "R6", 3);

      // trie for the remaining cases
      wr_node(0, 15'h0021, 16'h0409, 1, 10);
      wr_node(1, 15'h0001, 16'h0001, 1, 40);
      wr_node(2, 15'h1002, 16'h0000, 0, 20);
      wr_node(3, 15'h0000, 16'h0220, 8, 0);
      wr_node(8, 15'h0004, 16'h0000, 0, 30);
      wr_node(9, 15'h0000, 16'h0000, 0, 0);
      wr_res(10, 8'h11); wr_res(11, 8'h22); wr_res(20, 8'h66);
      wr_res(21, 8'h33); wr_res(30, 8'h44); wr_res(40, 8'h55);

      do_lookup(32'h0000_0000, "R9", 0);  // eight-level self loop
      do_lookup(32'h3A00_0000, "R4", 0);  // length-3 prefix wins
      do_lookup(32'h3500_0000, "R4", 0);  // falls to length 1
      do_lookup(32'hA5F0_0000, "R3", 0);  // child slot via bit count
      do_lookup(32'hA900_0000, "R4", 0);  // deeper node empty, keep root match
      do_lookup(32'h7000_0000, "R3", 0);  // branch bit clear stops walk
      do_lookup(32'hB000_0000, "R5", 0);  // result index via bit count
      wr_res(11, 8'h77);
      do_lookup(32'hB000_0000, "R2", 0);  // rewrite visible
      do_lookup(32'h3A00_0000, "R8", 6);  // held response
      do_lookup(32'h0000_0000, "R8", 2);

      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule